// File: doc/BRIEF.md
# Key-Protected Flash Command Sequencer

This block is the command front end of an on-chip non-volatile memory controller. Software writes a 16-bit control word. The upper byte must carry the execution key 0xA5, and bits 6:0 carry the command code. The sequencer checks the key and whether it is free to take a command. It then waits until the memory bus and the array are both idle, checks the command against the security bit and the per-region lock bits, and starts one operation at a time on an array stub. The stub stays busy for a fixed number of cycles.

Three states carry the flow. In `S_IDLE`, a write with a good key latches the code and the address and moves to `S_PEND` (transition *accept*). A write with a bad key stays in `S_IDLE` and sets the sticky programming-error bit (transition *reject*). `S_PEND` holds while the memory bus is busy (transition *defer*). Once the bus is free, a legal command moves to `S_BUSY` and starts the stub (transition *issue*). An illegal command returns to `S_IDLE` and sets the error bit (transition *refuse*). `S_BUSY` returns to `S_IDLE` when the stub reports done (transition *finish*). A write that arrives in `S_PEND` or `S_BUSY` is dropped and sets the error bit.

Top module: `nvm_cmd_seq`

## Requirements
- R1: A write whose bits 15:8 equal 0xA5 is accepted and runs the command code in bits 6:0 of the same write. The command runs one stub operation, and `arr_kick` pulses exactly once.
- R2: A write with any other key value starts nothing and sets `prog_err`.
- R3: A write that arrives while a command is pending or in progress is dropped and sets `prog_err`. The command already in flight keeps its code and completes normally.
- R4: `ready` is 1 when no command is in progress. It is 0 for exactly OP_CYCLES (default 4) cycles, starting in the cycle `arr_kick` is high. It then returns to 1.
- R5: While `mem_busy` is high, an accepted command stays pending and is not issued. It is issued at the first clock edge that samples `mem_busy` low.
- R6: `ctl_rdata` resets to 0x0000. Bits 6:0 read the last accepted code. Bit 8 reads 1 while the command is pending and 0 once it has been issued or refused. All other bits read 0.
- R7: Erase row (0x02) and write page (0x04) are refused with `prog_err` and no `arr_kick` when the lock bit of the target region is set. The region is the top log2(NREG) address bits, which is addr[15:12] by default.
- R8: Auxiliary erase (0x05) and auxiliary write (0x06) run only while `secure` is 0 and the address lies in the user row, halfword addresses 0xC000 to 0xC03F by default. Otherwise they are refused with `prog_err` and no `arr_kick`.
- R9: Lock (0x40) sets `lock_bits[region]` and unlock (0x41) clears it. Lock bits change only in a cycle in which `arr_kick` is high.
- R10: Code 0x42 sets `prm_on` and code 0x43 clears it.
- R11: Code 0x44 pulses `pbuf_clr` for one cycle, and code 0x46 pulses `cache_inv` for one cycle.
- R12: Code 0x45 sets `secure`, which then stays set until reset.
- R13: Every other code is reserved. A reserved code sets `prog_err`, starts nothing and changes no lock, security or power state.
- R14: A cycle with `err_clr` high clears `prog_err`. A new error in the same cycle wins, and the bit is left set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | One-cycle strobe for a control-word write |
| ctl_wdata | input | 16 | Control word: key in 15:8, code in 6:0 |
| nvm_addr | input | AW | Halfword address, latched together with the command |
| err_clr | input | 1 | Write-one-to-clear for the error bit |
| mem_busy | input | 1 | Memory-bus access in this cycle; it has priority over commands |
| ctl_rdata | output | 16 | Control-word readback |
| ready | output | 1 | High when no command is in progress |
| prog_err | output | 1 | Sticky programming error |
| secure | output | 1 | Security bit |
| prm_on | output | 1 | Power-reduction mode |
| lock_bits | output | NREG | Per-region lock state |
| arr_kick | output | 1 | Pulses when an operation starts |
| pbuf_clr | output | 1 | Page-buffer clear pulse |
| cache_inv | output | 1 | Cache invalidate pulse |

## Verification
The assertions take for granted that reset is asserted before the first clock edge and that every input holds a known value from then on. They also treat `ctl_wr` as a single-cycle strobe per write and `mem_busy` as a level that may stay high for any number of cycles. The bench changes inputs only on falling clock edges and pulses `ctl_wr` for one cycle per write. It holds `mem_busy` high across several edges to exercise deferral, and it raises `err_clr` only as a one-cycle pulse.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam logic [7:0] EXEC_KEY      = 8'hA5;

    localparam logic [6:0] OP_ERASE_ROW  = 7'h02;
    localparam logic [6:0] OP_WRITE_PAGE = 7'h04;
    localparam logic [6:0] OP_ERASE_AUX  = 7'h05;
    localparam logic [6:0] OP_WRITE_AUX  = 7'h06;
    localparam logic [6:0] OP_LOCK       = 7'h40;
    localparam logic [6:0] OP_UNLOCK     = 7'h41;
    localparam logic [6:0] OP_PRM_SET    = 7'h42;
    localparam logic [6:0] OP_PRM_CLR    = 7'h43;
    localparam logic [6:0] OP_PBUF_CLR   = 7'h44;
    localparam logic [6:0] OP_SECURE     = 7'h45;
    localparam logic [6:0] OP_CACHE_INV  = 7'h46;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PEND = 2'd1,
        S_BUSY = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic legal;
        logic lock_set;
        logic lock_clr;
        logic prm_set;
        logic prm_clr;
        logic pbuf_clr;
        logic sec_set;
        logic cache_inv;
    } cmd_action_t;

endpackage

// File: rtl/nvm_cmd_check.sv
module nvm_cmd_check
    import nvm_cmd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NREG      = 16,
    parameter int UROW_BASE = 'hC000,
    parameter int ROW_HW    = 64,
    localparam int RB       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [6:0]      cmd,
    input  logic [AW-1:0]   addr,
    input  logic            secure,
    input  logic [NREG-1:0] lock_bits,
    output cmd_action_t     act,
    output logic [RB-1:0]   region
);

    localparam logic [AW:0] UBASE = (AW+1)'(UROW_BASE);
    localparam logic [AW:0] UEND  = (AW+1)'(UROW_BASE + ROW_HW);

    logic in_urow;
    logic reg_locked;

    always_comb begin
        region     = addr[AW-1 -: RB];
        reg_locked = lock_bits[region];
        in_urow    = ({1'b0, addr} >= UBASE) && ({1'b0, addr} < UEND);
        act        = '0;
        case (cmd)
            OP_ERASE_ROW, OP_WRITE_PAGE: act.legal = !reg_locked;
            OP_ERASE_AUX, OP_WRITE_AUX:  act.legal = !secure && in_urow;
            OP_LOCK:      begin act.legal = 1'b1; act.lock_set  = 1'b1; end
            OP_UNLOCK:    begin act.legal = 1'b1; act.lock_clr  = 1'b1; end
            OP_PRM_SET:   begin act.legal = 1'b1; act.prm_set   = 1'b1; end
            OP_PRM_CLR:   begin act.legal = 1'b1; act.prm_clr   = 1'b1; end
            OP_PBUF_CLR:  begin act.legal = 1'b1; act.pbuf_clr  = 1'b1; end
            OP_SECURE:    begin act.legal = 1'b1; act.sec_set   = 1'b1; end
            OP_CACHE_INV: begin act.legal = 1'b1; act.cache_inv = 1'b1; end
            default:      act = '0;
        endcase
    end

endmodule

// File: rtl/nvm_array_stub.sv
module nvm_array_stub #(
    parameter int OP_CYCLES = 4,
    localparam int CW       = $clog2(OP_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= CW'(OP_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    // An operation may only start on an idle array.
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_cmd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NREG      = 16,
    parameter int UROW_BASE = 'hC000,
    parameter int ROW_HW    = 64,
    parameter int OP_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [15:0]     ctl_wdata,
    input  logic [AW-1:0]   nvm_addr,
    input  logic            err_clr,
    input  logic            mem_busy,
    output logic [15:0]     ctl_rdata,
    output logic            ready,
    output logic            prog_err,
    output logic            secure,
    output logic            prm_on,
    output logic [NREG-1:0] lock_bits,
    output logic            arr_kick,
    output logic            pbuf_clr,
    output logic            cache_inv
);

    localparam int RB = (NREG > 1) ? $clog2(NREG) : 1;

    seq_state_t      state_q, state_d;
    logic [6:0]      cmd_q;
    logic [AW-1:0]   addr_q;
    logic [NREG-1:0] lock_q;
    logic            sec_q, prm_q, err_q;
    logic            accept, issue, bad;
    logic            key_ok;
    logic            arr_busy, arr_done;
    cmd_action_t     act;
    logic [RB-1:0]   region;
    logic            unused_wbit7;

    assign unused_wbit7 = ctl_wdata[7];
    assign key_ok       = (ctl_wdata[15:8] == EXEC_KEY);

    nvm_cmd_check #(
        .AW(AW), .NREG(NREG), .UROW_BASE(UROW_BASE), .ROW_HW(ROW_HW)
    ) u_check (
        .cmd(cmd_q), .addr(addr_q), .secure(sec_q), .lock_bits(lock_q),
        .act(act), .region(region)
    );

    nvm_array_stub #(.OP_CYCLES(OP_CYCLES)) u_array (
        .clk(clk), .rst_n(rst_n), .start(issue), .busy(arr_busy), .done(arr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        issue   = 1'b0;
        bad     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (ctl_wr) begin
                    if (key_ok) begin
                        accept  = 1'b1;
                        state_d = S_PEND;
                    end else begin
                        bad = 1'b1;
                    end
                end
            end
            S_PEND: begin
                if (ctl_wr) bad = 1'b1;
                if (!mem_busy && !arr_busy) begin
                    if (act.legal) begin
                        issue   = 1'b1;
                        state_d = S_BUSY;
                    end else begin
                        bad     = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            S_BUSY: begin
                if (ctl_wr) bad = 1'b1;
                if (arr_done) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Command registers, status and side effects
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            addr_q    <= '0;
            lock_q    <= '0;
            sec_q     <= 1'b0;
            prm_q     <= 1'b0;
            err_q     <= 1'b0;
            arr_kick  <= 1'b0;
            pbuf_clr  <= 1'b0;
            cache_inv <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q  <= ctl_wdata[6:0];
                addr_q <= nvm_addr;
            end
            err_q     <= (err_q & ~err_clr) | bad;
            arr_kick  <= issue;
            pbuf_clr  <= issue & act.pbuf_clr;
            cache_inv <= issue & act.cache_inv;
            if (issue) begin
                if (act.lock_set) lock_q[region] <= 1'b1;
                if (act.lock_clr) lock_q[region] <= 1'b0;
                if (act.prm_set)  prm_q <= 1'b1;
                if (act.prm_clr)  prm_q <= 1'b0;
                if (act.sec_set)  sec_q <= 1'b1;
            end
        end
    end

    assign ready     = (state_q != S_BUSY);
    assign ctl_rdata = {7'b0, (state_q == S_PEND), 1'b0, cmd_q};
    assign prog_err  = err_q;
    assign secure    = sec_q;
    assign prm_on    = prm_q;
    assign lock_bits = lock_q;

    assert_bad_key_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[15:8] != EXEC_KEY) |=> prog_err);

    assert_bus_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |=> !arr_kick);

    assert_kick_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_kick |-> !ready);

    assert_pend_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[8] && !mem_busy) |=> !ctl_rdata[8]);

    assert_lock_on_kick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_bits) |-> arr_kick);

    assert_secure_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        secure |=> secure);

endmodule

// File: tb/nvm_cmd_seq_tb.sv
module nvm_cmd_seq_tb;

    localparam int OPC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] nvm_addr = '0;
    logic        err_clr = 1'b0;
    logic        mem_busy = 1'b0;
    logic [15:0] ctl_rdata;
    logic        ready, prog_err, secure, prm_on, arr_kick, pbuf_clr, cache_inv;
    logic [15:0] lock_bits;

    int checks = 0;
    int errors = 0;
    int n_kick, n_low, n_pb, n_inv;

    always #5 clk = ~clk;

    nvm_cmd_seq #(.OP_CYCLES(OPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .nvm_addr(nvm_addr), .err_clr(err_clr), .mem_busy(mem_busy),
        .ctl_rdata(ctl_rdata), .ready(ready), .prog_err(prog_err),
        .secure(secure), .prm_on(prm_on), .lock_bits(lock_bits),
        .arr_kick(arr_kick), .pbuf_clr(pbuf_clr), .cache_inv(cache_inv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] key, input logic [6:0] cmd, input logic [15:0] a);
        ctl_wr    = 1'b1;
        ctl_wdata = {key, 1'b0, cmd};
        nvm_addr  = a;
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (!(ready && !ctl_rdata[8]) && g < 40) begin
            @(negedge clk);
            if (arr_kick)  n_kick++;
            if (!ready)    n_low++;
            if (pbuf_clr)  n_pb++;
            if (cache_inv) n_inv++;
            g++;
        end
        if (g >= 40) chk("R4 timeout", 0, 1);
    endtask

    task automatic run_cmd(input logic [7:0] key, input logic [6:0] cmd, input logic [15:0] a);
        n_kick = 0; n_low = 0; n_pb = 0; n_inv = 0;
        wr(key, cmd, a);
        wait_idle();
    endtask

    task automatic clr_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset readback", 32'(ctl_rdata), 0);
        chk("R4 reset ready", 32'(ready), 1);
        chk("R2 reset prog_err", 32'(prog_err), 0);
        chk("R9 reset locks", 32'(lock_bits), 0);
        chk("R12 reset secure", 32'(secure), 0);
    endtask

    task automatic t_bad_key();
        run_cmd(8'h5A, 7'h02, 16'h1000);
        chk("R2 bad key err", 32'(prog_err), 1);
        chk("R2 bad key no kick", n_kick, 0);
        clr_err();
        chk("R14 clear", 32'(prog_err), 0);
    endtask

    task automatic t_erase();
        wr(8'hA5, 7'h02, 16'h1000);
        chk("R6 pending bit", 32'(ctl_rdata), 32'h0102);
        n_kick = 0; n_low = 0; n_pb = 0; n_inv = 0;
        wait_idle();
        chk("R1 erase kick", n_kick, 1);
        chk("R4 busy length", n_low, OPC);
        chk("R1 no err", 32'(prog_err), 0);
        chk("R6 after issue", 32'(ctl_rdata), 32'h0002);
    endtask

    task automatic t_lock();
        run_cmd(8'hA5, 7'h40, 16'h3010);
        chk("R9 lock region 3", 32'(lock_bits), 32'h0008);
        run_cmd(8'hA5, 7'h02, 16'h3000);
        chk("R7 locked erase err", 32'(prog_err), 1);
        chk("R7 locked erase no kick", n_kick, 0);
        clr_err();
        run_cmd(8'hA5, 7'h04, 16'h3FFE);
        chk("R7 locked write no kick", n_kick, 0);
        chk("R7 locked write err", 32'(prog_err), 1);
        clr_err();
        run_cmd(8'hA5, 7'h04, 16'h4000);
        chk("R7 other region ok", n_kick, 1);
        run_cmd(8'hA5, 7'h41, 16'h3FFF);
        chk("R9 unlock", 32'(lock_bits), 0);
        chk("R9 no err", 32'(prog_err), 0);
    endtask

    task automatic t_aux();
        run_cmd(8'hA5, 7'h05, 16'hC000);
        chk("R8 aux erase in row", n_kick, 1);
        run_cmd(8'hA5, 7'h06, 16'hC03F);
        chk("R8 aux write row end", n_kick, 1);
        chk("R8 no err", 32'(prog_err), 0);
        run_cmd(8'hA5, 7'h05, 16'hC040);
        chk("R8 past row", n_kick, 0);
        chk("R8 past row err", 32'(prog_err), 1);
        clr_err();
        run_cmd(8'hA5, 7'h06, 16'hBFFF);
        chk("R8 below row", n_kick, 0);
        clr_err();
    endtask

    task automatic t_prm_pulses();
        run_cmd(8'hA5, 7'h42, 16'h0);
        chk("R10 prm set", 32'(prm_on), 1);
        run_cmd(8'hA5, 7'h43, 16'h0);
        chk("R10 prm clear", 32'(prm_on), 0);
        run_cmd(8'hA5, 7'h44, 16'h0);
        chk("R11 pbuf pulse", n_pb, 1);
        chk("R11 pbuf no inv", n_inv, 0);
        run_cmd(8'hA5, 7'h46, 16'h0);
        chk("R11 cache pulse", n_inv, 1);
        chk("R11 cache no pbuf", n_pb, 0);
    endtask

    task automatic t_reserved();
        logic [6:0] codes [5] = '{7'h00, 7'h03, 7'h07, 7'h47, 7'h7F};
        foreach (codes[k]) begin
            run_cmd(8'hA5, codes[k], 16'h3000);
            chk("R13 reserved err", 32'(prog_err), 1);
            chk("R13 reserved no kick", n_kick, 0);
            chk("R13 state unchanged", {lock_bits, 14'b0, prm_on, secure}, 0);
            clr_err();
        end
    endtask

    task automatic t_defer();
        mem_busy = 1'b1;
        n_kick = 0;
        wr(8'hA5, 7'h04, 16'h2000);
        for (int k = 0; k < 5; k++) begin
            chk("R5 held pending", {arr_kick, ctl_rdata[8]}, 32'b01);
            @(negedge clk);
        end
        mem_busy = 1'b0;
        @(negedge clk);
        chk("R5 issued after bus idle", 32'(arr_kick), 1);
        chk("R6 pend bit clears", 32'(ctl_rdata[8]), 0);
        wait_idle();
        chk("R5 no err", 32'(prog_err), 0);
    endtask

    task automatic t_collide();
        n_kick = 0; n_low = 0;
        wr(8'hA5, 7'h02, 16'h1000);
        wr(8'hA5, 7'h04, 16'h5000);
        chk("R3 kick of first", 32'(arr_kick), 1);
        n_kick = 1;
        chk("R3 second dropped err", 32'(prog_err), 1);
        chk("R3 code kept", 32'(ctl_rdata[6:0]), 32'h02);
        clr_err();
        chk("R14 clear during busy", 32'(prog_err), 0);
        wr(8'hA5, 7'h05, 16'hC000);
        chk("R3 busy write err", 32'(prog_err), 1);
        wait_idle();
        chk("R3 single operation", n_kick, 1);
        clr_err();
    endtask

    task automatic t_secure();
        run_cmd(8'hA5, 7'h45, 16'h0);
        chk("R12 secure set", 32'(secure), 1);
        run_cmd(8'hA5, 7'h05, 16'hC000);
        chk("R8 aux refused when secure", n_kick, 0);
        chk("R12 secure stays", 32'(secure), 1);
        err_clr = 1'b1;
        wr(8'h00, 7'h02, 16'h0);
        err_clr = 1'b0;
        chk("R14 set wins over clear", 32'(prog_err), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_key();
        t_erase();
        t_lock();
        t_aux();
        t_prm_pulses();
        t_reserved();
        t_defer();
        t_collide();
        t_secure();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule